// File: doc/BRIEF.md
# Up/Down General Purpose Timer Counter

A standalone 16-bit counter that steps once per qualified clock event, either up or down. The step source is either an internal timebase strobe or the rising edge of an external clock pin. The external pins are brought into the system clock domain through a synchroniser chain. Steps can be qualified by an external gate pin. The count direction comes from either a control bit or an external pin.

Host logic loads an initial count with one write strobe and sets the operating mode with a separate control write. Two modes are defined:

- **Event counting:** the output is held low after a load. It stays low until the count arrives at zero. It then latches high and the counter parks at zero.
- **Pulse generation:** the counter reloads its initial value at each arrival at zero and emits a single-cycle high pulse.

Each arrival at zero also sets a sticky interrupt status bit. A write-1 clear input clears it. Bus decoding and interrupt routing belong to the surrounding logic.

Top module: `gp_updown_counter`

## Requirements
- R1: After a synchronous active-low reset, `count_value` is 0, `cnt_out` is low and `irq_status` is low. The control register is also 0, which means event counting, down, internal steps and no gating.
- R2: A cycle with `cnt_wr` high sets `count_value` to `cnt_wdata` and records that value for reloads. It drives `cnt_out` low on the next cycle in every mode. A `cnt_wr` in the same cycle as a step takes priority over the step. A control write leaves the count unchanged.
- R3: Control bit 3 selects the step source. With bit 3 at 0, each cycle with `tick_int` high is a step. With bit 3 at 1, each low-to-high transition of `ext_clk` is a step, after a two-flop synchroniser and an edge detector. The count changes on the third rising clock edge after `ext_clk` is first sampled high. A level held high gives only one step.
- R4: Control bit 4 selects gating. With bit 4 at 1, steps count only while the synchronised `ext_gate` is high. With bit 4 at 0, `ext_gate` has no effect.
- R5: Control bit 5 selects the direction source. With bit 5 at 0, control bit 2 sets the direction (1 = up, 0 = down). With bit 5 at 1, the synchronised `ext_updown` pin sets it (1 = up). Arithmetic wraps modulo 2^16.
- R6: In event counting mode (control bits 1:0 = 00), a step from a nonzero count moves it by one. When the result is zero, `cnt_out` goes high and stays high until the next load. While the count is zero, steps are ignored until the next load.
- R7: In pulse mode (bits 1:0 = 01), a step whose result would be zero reloads the last loaded value instead. `cnt_out` is high for the cycle after each such reload step and low otherwise.
- R8: Control codes 10 and 11 are reserved. In those codes, steps are ignored, the count holds and `cnt_out` is low.
- R9: Each arrival at zero (R6) and each reload step (R7) sets `irq_status`. A cycle with `irq_clr` high clears it. A set in the same cycle as a clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wr | input | 1 | Load strobe for the initial count |
| cnt_wdata | input | 16 | Initial count value |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control word: [5] direction from pin, [4] gate from pin, [3] external clock, [2] up, [1:0] mode |
| tick_int | input | 1 | Internal timebase strobe, one step per high cycle |
| ext_clk | input | 1 | External clock pin, asynchronous |
| ext_gate | input | 1 | External gate pin, asynchronous |
| ext_updown | input | 1 | External direction pin, asynchronous, 1 = up |
| irq_clr | input | 1 | Write-1 clear of the interrupt status |
| cnt_out | output | 1 | Counter output (latched level or pulse) |
| irq_status | output | 1 | Sticky terminal-count status |
| count_value | output | 16 | Current count |

## Verification
The bench goes after the following corner cases:

- **Parking at zero.** A counter that failed to park would wrap past zero and pulse the output low again.
- **Up-count wrap through 0xFFFF into zero.** A wrong width or compare would miss the terminal event.
- **Pulse-mode reload.** Reloading the wrong value, or a step too late, shifts every later pulse.
- **Two-stage synchroniser latency and single-edge detection.** An error here gives early counts, or repeated counts on a held level.
- **Gating.** A gate that leaks lets counts through while the gate pin is low.
- **Reserved mode codes.** A design that treats them as a real mode would keep counting.
- **Race between interrupt set and clear.** A clear that wins would lose an event.

A cycle-true model in the bench checks every output every cycle under seeded random stimulus.

// File: rtl/gpc_pkg.sv
// Package gpc_pkg: shared types for the up/down timer counter.
// Assumes the control word layout listed in the brief.
package gpc_pkg;

    typedef enum logic [1:0] {
        GPC_EVENT = 2'b00,
        GPC_PULSE = 2'b01,
        GPC_RSV_A = 2'b10,
        GPC_RSV_B = 2'b11
    } gpc_mode_e;

    typedef struct packed {
        logic      dir_from_pin;   // [5]
        logic      gate_from_pin;  // [4]
        logic      clk_from_pin;   // [3]
        logic      dir_up;         // [2]
        gpc_mode_e mode;           // [1:0]
    } gpc_ctl_t;

    localparam int CTL_W = $bits(gpc_ctl_t);

endpackage

// File: rtl/gpc_sync.sv
// Module gpc_sync: multi-bit flop-chain synchroniser for asynchronous pins.
// Assumes each bit is an independent slow level; no cross-bit coherence.
module gpc_sync #(
    parameter int BITS   = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] d,
    output logic [BITS-1:0] q
);
    logic [STAGES-1:0][BITS-1:0] stg_q;

    // Shift the pin values through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpc_step_sel.sv
// Module gpc_step_sel: chooses the step source, applies the gate and
// picks the count direction. Assumes its pin inputs are already synchronous.
module gpc_step_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_from_pin,
    input  logic gate_from_pin,
    input  logic dir_from_pin,
    input  logic dir_up,
    input  logic tick_int,
    input  logic ext_clk_s,
    input  logic ext_gate_s,
    input  logic ext_dir_s,
    output logic step,
    output logic count_up
);
    logic clk_prev_q;
    logic ext_rise;
    logic raw_step;
    logic gate_ok;

    // Remember the previous synchronised clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev_q <= 1'b0;
        else        clk_prev_q <= ext_clk_s;
    end

    // Combine source, gate and direction selection
    always_comb begin
        ext_rise = ext_clk_s & ~clk_prev_q;
        raw_step = clk_from_pin ? ext_rise : tick_int;
        gate_ok  = gate_from_pin ? ext_gate_s : 1'b1;
        step     = raw_step & gate_ok;
        count_up = dir_from_pin ? ext_dir_s : dir_up;
    end
endmodule

// File: rtl/gpc_core.sv
// Module gpc_core: count register, reload register and output shaping for
// the event and pulse modes. Assumes step is a single-cycle qualified strobe.
module gpc_core
    import gpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  gpc_mode_e        mode,
    input  logic             step,
    input  logic             count_up,
    output logic [CNT_W-1:0] count,
    output logic             out_lvl,
    output logic             terminal
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] init_q;
    logic             out_q;
    logic [CNT_W-1:0] cnt_next;
    logic             hits_zero;
    logic             at_zero;

    // Next value and terminal-count detection
    always_comb begin
        cnt_next  = count_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        hits_zero = (cnt_next == '0);
        at_zero   = (cnt_q == '0);
        unique case (mode)
            GPC_EVENT: terminal = step && !load && !at_zero && hits_zero;
            GPC_PULSE: terminal = step && !load && hits_zero;
            default:   terminal = 1'b0;
        endcase
    end

    // Count, reload value and output register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            init_q <= '0;
            out_q  <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            init_q <= load_val;
            out_q  <= 1'b0;
        end else begin
            unique case (mode)
                GPC_EVENT: begin
                    if (step && !at_zero) cnt_q <= cnt_next;
                    if (terminal)         out_q <= 1'b1;
                end
                GPC_PULSE: begin
                    if (step) cnt_q <= hits_zero ? init_q : cnt_next;
                    out_q <= terminal;
                end
                default: out_q <= 1'b0;
            endcase
        end
    end

    assign count   = cnt_q;
    assign out_lvl = out_q;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)) && !out_q); // R2
    AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GPC_EVENT) && at_zero && !load |=> cnt_q == '0); // R6
    AST_LATCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GPC_EVENT) && out_q && !load |=> out_q); // R6
    AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode inside {GPC_RSV_A, GPC_RSV_B}) && !load |=> $stable(cnt_q) && !out_q); // R8
endmodule

// File: rtl/gp_updown_counter.sv
// Module gp_updown_counter: top of the general purpose up/down timer
// counter. Holds the control word and the sticky interrupt status.
// Assumes ext_* pins are asynchronous and slower than clk / 2.
module gp_updown_counter
    import gpc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tick_int,
    input  logic             ext_clk,
    input  logic             ext_gate,
    input  logic             ext_updown,
    input  logic             irq_clr,
    output logic             cnt_out,
    output logic             irq_status,
    output logic [CNT_W-1:0] count_value
);
    localparam int PIN_N = 3;

    gpc_ctl_t         ctl_q;
    logic             irq_q;
    logic [PIN_N-1:0] pins_s;
    logic             step;
    logic             count_up;
    logic             terminal;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= gpc_ctl_t'(ctl_wdata);
    end

    // Sticky interrupt status: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (terminal) irq_q <= 1'b1;
        else if (irq_clr)  irq_q <= 1'b0;
    end

    gpc_sync #(.BITS(PIN_N), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_updown, ext_gate, ext_clk}),
        .q     (pins_s)
    );

    gpc_step_sel i_step (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_from_pin  (ctl_q.clk_from_pin),
        .gate_from_pin (ctl_q.gate_from_pin),
        .dir_from_pin  (ctl_q.dir_from_pin),
        .dir_up        (ctl_q.dir_up),
        .tick_int      (tick_int),
        .ext_clk_s     (pins_s[0]),
        .ext_gate_s    (pins_s[1]),
        .ext_dir_s     (pins_s[2]),
        .step          (step),
        .count_up      (count_up)
    );

    gpc_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .mode     (ctl_q.mode),
        .step     (step),
        .count_up (count_up),
        .count    (count_value),
        .out_lvl  (cnt_out),
        .terminal (terminal)
    );

    assign irq_status = irq_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> irq_status); // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !terminal |=> !irq_status); // R9
endmodule

// File: tb/test_gp_updown_counter.sv
module test_gp_updown_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic        tick_int = 1'b0;
    logic        ext_clk = 1'b0;
    logic        ext_gate = 1'b0;
    logic        ext_updown = 1'b0;
    logic        irq_clr = 1'b0;
    logic        cnt_out;
    logic        irq_status;
    logic [15:0] count_value;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gp_updown_counter i_gp_updown_counter (
        .clk (clk), .rst_n (rst_n), .cnt_wr (cnt_wr), .cnt_wdata (cnt_wdata),
        .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata), .tick_int (tick_int),
        .ext_clk (ext_clk), .ext_gate (ext_gate), .ext_updown (ext_updown),
        .irq_clr (irq_clr), .cnt_out (cnt_out), .irq_status (irq_status),
        .count_value (count_value)
    );

    // Reference model state, written from the requirements
    logic [15:0] m_cnt, m_init;
    logic        m_out, m_irq, m_prev;
    logic [5:0]  m_ctl;
    logic [2:0]  m_s1, m_s2;

    function automatic logic mdl_step(input logic [5:0] c, input logic [2:0] s2,
                                      input logic prev, input logic tk);
        logic src;
        src = c[3] ? (s2[0] & ~prev) : tk;                         // R3
        return src & (c[4] ? s2[1] : 1'b1);                        // R4
    endfunction

    function automatic logic mdl_up(input logic [5:0] c, input logic [2:0] s2);
        return c[5] ? s2[2] : c[2];                                // R5
    endfunction

    always @(posedge clk) begin
        logic        stp, up, term;
        logic [15:0] nx;
        if (!rst_n) begin
            m_cnt = '0; m_init = '0; m_out = 1'b0; m_irq = 1'b0;
            m_prev = 1'b0; m_ctl = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            stp  = mdl_step(m_ctl, m_s2, m_prev, tick_int);
            up   = mdl_up(m_ctl, m_s2);
            nx   = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
            term = 1'b0;
            if (cnt_wr) begin
                m_cnt = cnt_wdata; m_init = cnt_wdata; m_out = 1'b0;   // R2
            end else begin
                case (m_ctl[1:0])
                    2'b00: if (stp && m_cnt != 0) begin                // R6
                        m_cnt = nx;
                        if (nx == 0) begin term = 1'b1; m_out = 1'b1; end
                    end
                    2'b01: begin                                       // R7
                        if (stp) begin
                            if (nx == 0) begin term = 1'b1; m_cnt = m_init; end
                            else m_cnt = nx;
                        end
                        m_out = term;
                    end
                    default: m_out = 1'b0;                             // R8
                endcase
            end
            if (term) m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;                            // R9
            m_prev = m_s2[0]; m_s2 = m_s1; m_s1 = {ext_updown, ext_gate, ext_clk};
            if (ctl_wr) m_ctl = ctl_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic string mode_tag(input logic [5:0] c);
        case (c[1:0])
            2'b00: return "R6";
            2'b01: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Cycle-by-cycle comparison against the model, away from the active edge
    bit cmp_en = 1'b0;
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk({mode_tag(m_ctl), " count"}, {16'd0, count_value}, {16'd0, m_cnt});
            chk({mode_tag(m_ctl), " out"}, {31'd0, cnt_out}, {31'd0, m_out});
            chk("R9 irq", {31'd0, irq_status}, {31'd0, m_irq});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; cyc(1); cnt_wr = 1'b0;
    endtask

    task automatic set_ctl(input logic [5:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; cyc(1); ctl_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_int = 1'b1; cyc(n); tick_int = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 count", {16'd0, count_value}, 32'd0);
        chk("R1 out", {31'd0, cnt_out}, 32'd0);
        chk("R1 irq", {31'd0, irq_status}, 32'd0);
        cmp_en = 1'b1;

        // R2: load and no effect of control write on count
        load(16'd5);
        chk("R2 load", {16'd0, count_value}, 32'd5);
        set_ctl(6'b000000);
        chk("R2 ctl keeps count", {16'd0, count_value}, 32'd5);

        // R6/R9: count down to zero, park, latch output
        ticks(5);
        chk("R6 zero", {16'd0, count_value}, 32'd0);
        chk("R6 out high", {31'd0, cnt_out}, 32'd1);
        chk("R9 set", {31'd0, irq_status}, 32'd1);
        ticks(3);
        chk("R6 parked", {16'd0, count_value}, 32'd0);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        chk("R9 clear", {31'd0, irq_status}, 32'd0);

        // R7: pulse mode reload
        set_ctl(6'b000001);
        load(16'd3);
        ticks(2);
        chk("R7 count", {16'd0, count_value}, 32'd1);
        chk("R7 no pulse", {31'd0, cnt_out}, 32'd0);
        ticks(1);
        chk("R7 reload", {16'd0, count_value}, 32'd3);
        chk("R7 pulse", {31'd0, cnt_out}, 32'd1);
        cyc(1);
        chk("R7 pulse ends", {31'd0, cnt_out}, 32'd0);

        // R8: reserved code holds
        set_ctl(6'b000010);
        ticks(4);
        chk("R8 hold", {16'd0, count_value}, 32'd3);
        chk("R8 out low", {31'd0, cnt_out}, 32'd0);

        // R5: direction from pin, up-count wrap into zero
        ext_updown = 1'b1;
        set_ctl(6'b100000);
        cyc(3);
        load(16'hFFFE);
        ticks(2);
        chk("R5 wrap to zero", {16'd0, count_value}, 32'd0);
        chk("R5 out", {31'd0, cnt_out}, 32'd1);
        ext_updown = 1'b0;

        // R3: external clock edge, latency and single count per edge
        set_ctl(6'b001000);
        load(16'd10);
        ext_clk = 1'b1;
        cyc(2);
        chk("R3 not yet", {16'd0, count_value}, 32'd10);
        cyc(1);
        chk("R3 edge", {16'd0, count_value}, 32'd9);
        cyc(5);
        chk("R3 held level", {16'd0, count_value}, 32'd9);
        ext_clk = 1'b0;
        cyc(3);

        // R4: gate low blocks steps
        set_ctl(6'b010000);
        load(16'd4);
        ticks(3);
        chk("R4 gated", {16'd0, count_value}, 32'd4);
        ext_gate = 1'b1;
        cyc(3);
        ticks(2);
        chk("R4 open", {16'd0, count_value}, 32'd2);

        // Seeded random mix, checked every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            cnt_wr     = ($urandom % 16) == 0;
            cnt_wdata  = ($urandom % 2) ? 16'($urandom % 8) : 16'($urandom);
            ctl_wr     = ($urandom % 40) == 0;
            ctl_wdata  = 6'($urandom);
            tick_int   = $urandom % 2;
            if (($urandom % 3) == 0) ext_clk = ~ext_clk;
            if (($urandom % 20) == 0) ext_gate = ~ext_gate;
            if (($urandom % 30) == 0) ext_updown = ~ext_updown;
            irq_clr    = ($urandom % 8) == 0;
            cyc(1);
        end
        cnt_wr = 1'b0; ctl_wr = 1'b0; tick_int = 1'b0; irq_clr = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule